// File: doc/BRIEF.md
# Test-Status Report Byte Serializer

This block turns status events from a memory tester into short byte messages for a serial transmitter. Two single-cycle trigger inputs are watched: one signals that a test loop has finished, and the other signals a failure. On a failure, the error code, the failing address and the expected data value are captured at the moment of the trigger. The triggers may fall again before the message is sent.

The message that matches the event is then sent one byte at a time over a valid/accept handshake. Every message ends with carriage return (0x0D) and then line feed (0x0A). After each accepted byte, valid drops for one cycle. With accept held high, a new byte therefore appears every second clock. A transmitter that stalls accept holds the current byte in place for as long as needed.

A message that is in flight is never interrupted. Triggers that arrive while a message is being sent are dropped.

Top module: `uerr_report_ser`

## Requirements
- R1: While rst_ni is low, and after reset until a trigger is sampled, tx_valid_o is 0.
- R2: A loop-done trigger produces exactly 6 bytes in this order: 0x4C ('L'), 0x00, 0x00, 0x00, 0x0D, 0x0A.
- R3: An error trigger produces exactly 8 bytes in this order: 0x45 ('E'), error code, address low byte, address high byte, expected-data byte, actual-data byte, 0x0D, 0x0A.
- R4: The address is sent little-endian as two bytes, and the high byte is zero-extended (address 0x3EF gives 0xEF then 0x03).
- R5: The expected-data byte is the 1-bit expected value zero-extended to 8 bits. The actual-data byte is its complement, also zero-extended (expected 1 gives 0x01 then 0x00).
- R6: With tx_accept_i held high, valid is high for one cycle and then low for one cycle between bytes. While valid is high and accept is low, valid and tx_data_o hold their values.
- R7: Code, address and expected data are latched on the cycle the trigger is sampled. Changes on those inputs afterwards do not alter the message.
- R8: Triggers that arrive while a message is in progress are ignored: the current message completes unchanged, and no bytes follow it.
- R9: If both triggers are sampled in the same cycle, the error message is sent.
- R10: After the final 0x0A byte is accepted, tx_valid_o stays low until a new trigger arrives.
- R11: The first byte is valid in the cycle that follows the clock edge at which the trigger was sampled in the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| loop_done_i | input | 1 | Loop-complete trigger pulse |
| err_i | input | 1 | Error trigger pulse |
| err_code_i | input | CODE_W | Error state code, latched at trigger |
| err_addr_i | input | ADDR_W | Failing address, latched at trigger |
| err_exp_i | input | DATA_W | Expected data value, latched at trigger |
| tx_accept_i | input | 1 | Transmitter accepts the current byte |
| tx_valid_o | output | 1 | Byte on tx_data_o is valid |
| tx_data_o | output | 8 | Message byte |

## Verification
The bench uses the default parameters: a 10-bit address, 1-bit data, an 8-bit code and three padding bytes. The 10-bit address is split across two bytes and leaves the high byte only partly filled, so addresses 0x3EF, 0x100 and 0x0FF each show that byte order and zero-extension are correct. With 1-bit data, the zero-extension and the complement of the actual-data byte can be checked for both polarities. Directed tests also cover stalled accept, mid-message triggers, simultaneous triggers and field inputs that change after the trigger.

// File: rtl/uerr_pkg.sv
package uerr_pkg;

  typedef enum logic {MSG_LOOP = 1'b0, MSG_ERR = 1'b1} msg_kind_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_SHOW = 2'd1, ST_GAP = 2'd2} seq_st_e;

  localparam logic [7:0] CH_L  = 8'h4C;
  localparam logic [7:0] CH_E  = 8'h45;
  localparam logic [7:0] CH_CR = 8'h0D;
  localparam logic [7:0] CH_LF = 8'h0A;

  function automatic int bytes_of(input int bits);
    return (bits + 7) / 8;
  endfunction

  function automatic int err_len(input int addr_w, input int data_w);
    return 2 + bytes_of(addr_w) + 2 * bytes_of(data_w) + 2;
  endfunction

  function automatic int loop_len(input int pad);
    return 1 + pad + 2;
  endfunction

endpackage

// File: rtl/uerr_capture.sv
module uerr_capture
  import uerr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 1,
  parameter int CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              err_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] exp_i,
  output msg_kind_e         kind_o,
  output logic [CODE_W-1:0] code_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] exp_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_o <= MSG_LOOP;
      code_o <= '0;
      addr_o <= '0;
      exp_o  <= '0;
    end else if (start_i) begin
      // error wins when both triggers coincide
      kind_o <= err_i ? MSG_ERR : MSG_LOOP;
      code_o <= code_i;
      addr_o <= addr_i;
      exp_o  <= exp_i;
    end
  end

  AST_FIELDS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(code_o) && $stable(addr_o) && $stable(exp_o) && $stable(kind_o))); // R7
  AST_ERR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && err_i) |=> (kind_o == MSG_ERR)); // R9

endmodule

// File: rtl/uerr_formatter.sv
module uerr_formatter
  import uerr_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 1,
  parameter int CODE_W   = 8,
  parameter int LOOP_PAD = 3,
  parameter int IDX_W    = 3
) (
  input  msg_kind_e         kind_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] exp_i,
  output logic [7:0]        byte_o
);

  localparam int AB   = bytes_of(ADDR_W);
  localparam int DB   = bytes_of(DATA_W);
  localparam int ELEN = err_len(ADDR_W, DATA_W);
  localparam int LLEN = loop_len(LOOP_PAD);

  logic [AB*8-1:0] addr_ext;
  logic [DB*8-1:0] exp_ext, act_ext;
  logic [7:0]      code_ext;
  logic [7:0]      addr_b [AB];
  logic [7:0]      exp_b  [DB];
  logic [7:0]      act_b  [DB];
  logic [7:0]      err_msg  [ELEN];
  logic [7:0]      loop_msg [LLEN];

  always_comb begin
    addr_ext = '0;
    addr_ext[ADDR_W-1:0] = addr_i;
    exp_ext = '0;
    exp_ext[DATA_W-1:0] = exp_i;
    act_ext = '0;
    act_ext[DATA_W-1:0] = ~exp_i;
    code_ext = '0;
    code_ext[CODE_W-1:0] = code_i;
  end

  for (genvar g = 0; g < AB; g++) begin : g_addr
    assign addr_b[g] = addr_ext[g*8 +: 8];
  end
  for (genvar g = 0; g < DB; g++) begin : g_data
    assign exp_b[g] = exp_ext[g*8 +: 8];
    assign act_b[g] = act_ext[g*8 +: 8];
  end

  always_comb begin
    err_msg[0] = CH_E;
    err_msg[1] = code_ext;
    for (int a = 0; a < AB; a++) err_msg[2+a] = addr_b[a];
    for (int d = 0; d < DB; d++) begin
      err_msg[2+AB+d]    = exp_b[d];
      err_msg[2+AB+DB+d] = act_b[d];
    end
    err_msg[ELEN-2] = CH_CR;
    err_msg[ELEN-1] = CH_LF;
  end

  always_comb begin
    loop_msg[0] = CH_L;
    for (int p = 0; p < LOOP_PAD; p++) loop_msg[1+p] = 8'h00;
    loop_msg[LLEN-2] = CH_CR;
    loop_msg[LLEN-1] = CH_LF;
  end

  always_comb begin
    byte_o = 8'h00;
    if (kind_i == MSG_ERR) begin
      for (int i = 0; i < ELEN; i++)
        if (idx_i == IDX_W'(i)) byte_o = err_msg[i];
    end else begin
      for (int i = 0; i < LLEN; i++)
        if (idx_i == IDX_W'(i)) byte_o = loop_msg[i];
    end
  end

  always_comb begin
    if (kind_i == MSG_ERR && idx_i == IDX_W'(ELEN-1))
      AST_ERR_TAIL_LF: assert (byte_o == CH_LF); // R3
  end

endmodule

// File: rtl/uerr_sequencer.sv
module uerr_sequencer
  import uerr_pkg::*;
#(
  parameter int ELEN  = 8,
  parameter int LLEN  = 6,
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             loop_i,
  input  logic             err_i,
  input  logic             accept_i,
  input  msg_kind_e        kind_i,
  output logic             start_o,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);

  seq_st_e          st_q;
  logic             last;
  logic [IDX_W-1:0] last_idx;

  assign last_idx = (kind_i == MSG_ERR) ? IDX_W'(ELEN - 1) : IDX_W'(LLEN - 1);
  assign last     = (idx_o == last_idx);
  assign start_o  = (st_q == ST_IDLE) && (loop_i || err_i);
  assign valid_o  = (st_q == ST_SHOW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      idx_o <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_o) begin
          st_q  <= ST_SHOW;
          idx_o <= '0;
        end
        ST_SHOW: if (accept_i) begin
          st_q  <= last ? ST_IDLE : ST_GAP;
          idx_o <= last ? '0 : idx_o + 1'b1;
        end
        ST_GAP:  st_q <= ST_SHOW;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_QUIET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !loop_i && !err_i) |=> !valid_o); // R1
  AST_FIRST_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> (valid_o && idx_o == '0)); // R11
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !accept_i) |=> (valid_o && $stable(idx_o))); // R6
  AST_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && accept_i) |=> !valid_o); // R6
  AST_NO_OVERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (idx_o <= last_idx)); // R10
  AST_END_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && accept_i && last) |=> (st_q == ST_IDLE)); // R10
  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |-> !start_o); // R8

endmodule

// File: rtl/uerr_report_ser.sv
module uerr_report_ser
  import uerr_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 1,
  parameter int CODE_W   = 8,
  parameter int LOOP_PAD = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              loop_done_i,
  input  logic              err_i,
  input  logic [CODE_W-1:0] err_code_i,
  input  logic [ADDR_W-1:0] err_addr_i,
  input  logic [DATA_W-1:0] err_exp_i,
  input  logic              tx_accept_i,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o
);

  localparam int ELEN  = err_len(ADDR_W, DATA_W);
  localparam int LLEN  = loop_len(LOOP_PAD);
  localparam int MLEN  = (ELEN > LLEN) ? ELEN : LLEN;
  localparam int IDX_W = (MLEN > 2) ? $clog2(MLEN) : 1;

  msg_kind_e         kind_q;
  logic              start;
  logic [IDX_W-1:0]  idx;
  logic [CODE_W-1:0] code_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] exp_q;

  uerr_sequencer #(.ELEN(ELEN), .LLEN(LLEN), .IDX_W(IDX_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .loop_i   (loop_done_i),
    .err_i    (err_i),
    .accept_i (tx_accept_i),
    .kind_i   (kind_q),
    .start_o  (start),
    .valid_o  (tx_valid_o),
    .idx_o    (idx)
  );

  uerr_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .err_i   (err_i),
    .code_i  (err_code_i),
    .addr_i  (err_addr_i),
    .exp_i   (err_exp_i),
    .kind_o  (kind_q),
    .code_o  (code_q),
    .addr_o  (addr_q),
    .exp_o   (exp_q)
  );

  uerr_formatter #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W),
    .LOOP_PAD(LOOP_PAD), .IDX_W(IDX_W)
  ) u_fmt (
    .kind_i (kind_q),
    .idx_i  (idx),
    .code_i (code_q),
    .addr_i (addr_q),
    .exp_i  (exp_q),
    .byte_o (tx_data_o)
  );

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_accept_i) |=> $stable(tx_data_o)); // R6

endmodule

// File: tb/uerr_report_ser_tb.sv
`timescale 1ns/1ps
module uerr_report_ser_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       loop_done = 1'b0;
  logic       err = 1'b0;
  logic [7:0] code = '0;
  logic [9:0] addr = '0;
  logic [0:0] expd = '0;
  logic       accept = 1'b1;
  logic       valid;
  logic [7:0] data;

  int checks = 0;
  int fails  = 0;
  logic [7:0] eb [8];

  always #2.5 clk = ~clk;

  uerr_report_ser dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .loop_done_i (loop_done),
    .err_i       (err),
    .err_code_i  (code),
    .err_addr_i  (addr),
    .err_exp_i   (expd),
    .tx_accept_i (accept),
    .tx_valid_o  (valid),
    .tx_data_o   (data)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Called at the negedge where byte 0 is first valid; accept held high.
  task automatic run_msg(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      chk(valid == 1'b1, {tag, " valid R6"}, valid, 1);
      chk(data == eb[i], {tag, " byte"}, data, eb[i]);
      @(negedge clk);
      chk(valid == 1'b0, {tag, " gap R6"}, valid, 0);
      if (i < n - 1) @(negedge clk);
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(valid == 1'b0, {tag, " no extra R10"}, valid, 0);
    end
  endtask

  task automatic pulse(input logic lp, input logic er);
    loop_done = lp;
    err = er;
    @(negedge clk);
    loop_done = 1'b0;
    err = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(valid == 1'b0, "R1 in reset", valid, 0);
    end
    rst_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(valid == 1'b0, "R1 after reset", valid, 0);
    end
  endtask

  task automatic t_loop();
    accept = 1'b1;
    pulse(1'b1, 1'b0);
    chk(valid == 1'b1, "R11 first byte", valid, 1);
    eb[0] = 8'h4C; eb[1] = 8'h00; eb[2] = 8'h00; eb[3] = 8'h00;
    eb[4] = 8'h0D; eb[5] = 8'h0A;
    run_msg(6, "R2 loop");
  endtask

  task automatic t_error(input logic [7:0] c, input logic [9:0] a, input logic e);
    accept = 1'b1;
    code = c; addr = a; expd = e;
    pulse(1'b0, 1'b1);
    code = ~c; addr = ~a; expd = ~e;   // R7: late changes must not leak
    eb[0] = 8'h45; eb[1] = c; eb[2] = a[7:0]; eb[3] = {6'b0, a[9:8]};
    eb[4] = {7'b0, e}; eb[5] = {7'b0, ~e}; eb[6] = 8'h0D; eb[7] = 8'h0A;
    run_msg(8, "R3 R4 R5 R7 err");
  endtask

  task automatic t_stall();
    accept = 1'b0;
    pulse(1'b1, 1'b0);
    repeat (4) begin
      chk(valid == 1'b1, "R6 stall valid", valid, 1);
      chk(data == 8'h4C, "R6 stall data", data, 8'h4C);
      @(negedge clk);
    end
    accept = 1'b1;
    eb[0] = 8'h4C; eb[1] = 8'h00; eb[2] = 8'h00; eb[3] = 8'h00;
    eb[4] = 8'h0D; eb[5] = 8'h0A;
    run_msg(6, "R6 stall loop");
  endtask

  task automatic t_ignore();
    accept = 1'b0;
    pulse(1'b1, 1'b0);
    code = 8'h77; addr = 10'h2AA; expd = 1'b1;
    pulse(1'b0, 1'b1);               // mid-message trigger
    pulse(1'b1, 1'b1);
    chk(data == 8'h4C, "R8 still loop", data, 8'h4C);
    accept = 1'b1;
    eb[0] = 8'h4C; eb[1] = 8'h00; eb[2] = 8'h00; eb[3] = 8'h00;
    eb[4] = 8'h0D; eb[5] = 8'h0A;
    run_msg(6, "R8 ignore");
  endtask

  task automatic t_both();
    accept = 1'b1;
    code = 8'h07; addr = 10'h0FF; expd = 1'b1;
    pulse(1'b1, 1'b1);
    eb[0] = 8'h45; eb[1] = 8'h07; eb[2] = 8'hFF; eb[3] = 8'h00;
    eb[4] = 8'h01; eb[5] = 8'h00; eb[6] = 8'h0D; eb[7] = 8'h0A;
    run_msg(8, "R9 both");
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_loop();
    t_error(8'h02, 10'h3EF, 1'b1);
    t_error(8'hA5, 10'h100, 1'b0);
    t_stall();
    t_ignore();
    t_both();
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R6 watchdog: actual=running expected=done");
    summary();
    $finish;
  end

endmodule